// File: doc/BRIEF.md
# Dual-Channel Drive Interrupt Gate

This block is the small register file of a two-channel disk adapter card, reached over a byte-wide host bus with separate read and write strobes. For each channel it keeps an interrupt gate, built as a two-state machine. A write of any byte to the channel's gate address opens the gate. A read of that same address closes it. The card's single interrupt output is raised while any channel has both an open gate and an active drive interrupt line. The drive task-file registers and the DMA engine are outside this block.

The host can also do the following:
- Read each channel's raw drive interrupt line in bit 0 of a status address.
- Read a 4-bit board identity, one bit per word-spaced address. A value of 3 marks the two-channel board and a value of 15 marks the single-channel board.
- Program a control byte. Its bit 0 routes the DMA request and acknowledge pair to one channel. Its bit 5 opens the extended task-file window. Writing zero closes the window and makes the boot ROM visible again.

Each channel gate has two states, MASKED and ARMED. It has three transitions:
- ARM: a write hit moves MASKED or ARMED to ARMED.
- DISARM: a valid read hit moves ARMED to MASKED.
- HOLD: with no hit, the gate keeps its state.

Reset forces every gate to MASKED.

Read data is registered. It appears in the cycle after the read strobe and is zero in every other cycle.

Top module: `ide_irq_gate`

## Requirements
- R1: After reset, both gates are MASKED, the control byte is 0x00, `card_irq_o`, `dma_chan_o` and `tf_window_o` are 0, `boot_rom_o` is 1, and `bus_rdata_o` is 0.
- R2: A write of any data byte to a gate address sets that channel's gate to ARMED. The gate addresses are 0x2200 for channel 0 and 0x3200 for channel 1.
- R3: A valid read of a gate address returns the gate state before the read in bit 0, with bits 7..1 zero, on `bus_rdata_o` in the next cycle. The same read sets that gate to MASKED. The other channel's gate is not touched.
- R4: A valid read of a status address returns that channel's `drv_irq_i` bit, as sampled at the read edge, in bit 0, whatever the gate state. The status addresses are 0x2290 for channel 0 and 0x3290 for channel 1. The read has no side effect.
- R5: Reads of addresses 0x2280, 0x2284, 0x2288 and 0x228C return `id_strap_i` bits 0, 1, 2 and 3 respectively in bit 0.
- R6: A write to address 0x0000 stores the whole byte in the control register, and a read there returns it. `dma_chan_o` follows bit 0 of the control register and `tf_window_o` follows bit 5.
- R7: Writing 0x00 to the control register clears `tf_window_o` and sets `boot_rom_o`. `boot_rom_o` is always the inverse of `tf_window_o`.
- R8: `card_irq_o` is combinationally the OR, over the channels, of (gate ARMED AND `drv_irq_i` bit).
- R9: Reads of unmapped addresses return 0 and change no state. Writes to unmapped, status or identity addresses change no state.
- R10: When `bus_rd_i` and `bus_wr_i` are high in the same cycle, the read is ignored: it has no clear side effect and returns zero data. The write is carried out.
- R11: `bus_rdata_o` is 0 in every cycle that does not follow a valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data, valid the cycle after a read |
| drv_irq_i | input | NUM_CH | Interrupt line of each channel's drive |
| id_strap_i | input | ID_W | Board identity straps |
| card_irq_o | output | 1 | Gated card interrupt |
| dma_chan_o | output | 1 | Channel receiving the DMA request and acknowledge pair |
| tf_window_o | output | 1 | Extended task-file window open |
| boot_rom_o | output | 1 | Boot ROM mapped in place of the window |

## Verification
The assertions check the following on every cycle:
- Each gate's ARM and DISARM transitions, and that a gate holds its state when neither applies.
- That the control register loads on a write and holds otherwise.
- That read data is zero outside a valid read and for unmapped offsets.
- That status reads echo the drive line.

Some behaviours can only be shown by the bench's scenarios:
- Channel isolation of the read-to-clear side effect.
- The exact identity bit order.
- The interplay of gate and line on the card interrupt.
- That writes to read-only offsets leave the gates unchanged.
- The collided read-and-write case, seen through later reads.

// File: rtl/ide_irq_gate_pkg.sv
package ide_irq_gate_pkg;

    // Address map constants, shared by decoder and checker logic
    localparam int unsigned GATE_BASE   = 32'h2200;
    localparam int unsigned CH_STRIDE   = 32'h1000;
    localparam int unsigned STAT_OFS    = 32'h0090;
    localparam int unsigned ID_BASE     = 32'h2280;
    localparam int unsigned ID_STEP     = 32'h0004;
    localparam int unsigned CTRL_ADDR   = 32'h0000;

    // Control byte bit positions decoded by neighbours
    localparam int unsigned CTRL_DMA_BIT = 0;
    localparam int unsigned CTRL_WIN_BIT = 5;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_GATE,
        ACC_STAT,
        ACC_ID
    } acc_kind_e;

    typedef enum logic {
        CH_MASKED = 1'b0,
        CH_ARMED  = 1'b1
    } gate_state_e;

endpackage

// File: rtl/ide_irq_gate_decode.sv
module ide_irq_gate_decode
    import ide_irq_gate_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int NUM_CH = 2,
    parameter int ID_W   = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [CH_W-1:0]   ch_o,
    output logic [IDX_W-1:0]  idx_o
);

    always_comb begin
        kind_o = ACC_NONE;
        ch_o   = '0;
        idx_o  = '0;
        if (addr_i == ADDR_W'(CTRL_ADDR)) begin
            kind_o = ACC_CTRL;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr_i == ADDR_W'(GATE_BASE + 32'(c) * CH_STRIDE)) begin
                kind_o = ACC_GATE;
                ch_o   = CH_W'(c);
            end
            if (addr_i == ADDR_W'(GATE_BASE + 32'(c) * CH_STRIDE + STAT_OFS)) begin
                kind_o = ACC_STAT;
                ch_o   = CH_W'(c);
            end
        end
        for (int k = 0; k < ID_W; k++) begin
            if (addr_i == ADDR_W'(ID_BASE + 32'(k) * ID_STEP)) begin
                kind_o = ACC_ID;
                idx_o  = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/ide_irq_gate_chan.sv
module ide_irq_gate_chan
    import ide_irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic disarm_i,
    input  logic line_i,
    output logic armed_o,
    output logic req_o
);

    gate_state_e state_q, state_d;

    // Next-state logic: ARM has priority over DISARM, otherwise HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_MASKED: if (arm_i) state_d = CH_ARMED;
            CH_ARMED:  if (!arm_i && disarm_i) state_d = CH_MASKED;
            default:   state_d = CH_MASKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        armed_o = (state_q == CH_ARMED);
        req_o   = armed_o & line_i;
    end

    assert_write_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> armed_o);

    assert_read_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm_i && !arm_i) |=> !armed_o);

    assert_gate_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !disarm_i) |=> $stable(armed_o));

endmodule

// File: rtl/ide_irq_gate_ctrl.sv
module ide_irq_gate_ctrl
    import ide_irq_gate_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              dma_chan_o,
    output logic              tf_window_o,
    output logic              boot_rom_o
);

    logic [DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_en_i) ctrl_q <= wdata_i;
    end

    always_comb begin
        ctrl_o      = ctrl_q;
        dma_chan_o  = ctrl_q[CTRL_DMA_BIT];
        tf_window_o = ctrl_q[CTRL_WIN_BIT];
        boot_rom_o  = ~ctrl_q[CTRL_WIN_BIT];
    end

    assert_ctrl_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (ctrl_o == $past(wdata_i)));

    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(ctrl_o));

    assert_rom_inverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        boot_rom_o != tf_window_o);

endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate
    import ide_irq_gate_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    parameter int NUM_CH = 2,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NUM_CH-1:0] drv_irq_i,
    input  logic [ID_W-1:0]   id_strap_i,
    output logic              card_irq_o,
    output logic              dma_chan_o,
    output logic              tf_window_o,
    output logic              boot_rom_o
);

    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;

    acc_kind_e          dec_kind;
    logic [CH_W-1:0]    dec_ch;
    logic [IDX_W-1:0]   dec_idx;
    logic               rd_ok;
    logic [NUM_CH-1:0]  arm, disarm, armed, req;
    logic [DATA_W-1:0]  ctrl_val;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;

    // A read colliding with a write is dropped
    assign rd_ok = bus_rd_i & ~bus_wr_i;

    ide_irq_gate_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .ID_W   (ID_W)
    ) u_decode (
        .addr_i (bus_addr_i),
        .kind_o (dec_kind),
        .ch_o   (dec_ch),
        .idx_o  (dec_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign arm[c]    = bus_wr_i & (dec_kind == ACC_GATE) & (dec_ch == CH_W'(c));
        assign disarm[c] = rd_ok    & (dec_kind == ACC_GATE) & (dec_ch == CH_W'(c));

        ide_irq_gate_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (arm[c]),
            .disarm_i (disarm[c]),
            .line_i   (drv_irq_i[c]),
            .armed_o  (armed[c]),
            .req_o    (req[c])
        );
    end

    ide_irq_gate_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (bus_wr_i && (dec_kind == ACC_CTRL)),
        .wdata_i     (bus_wdata_i),
        .ctrl_o      (ctrl_val),
        .dma_chan_o  (dma_chan_o),
        .tf_window_o (tf_window_o),
        .boot_rom_o  (boot_rom_o)
    );

    always_comb begin
        rd_mux = '0;
        unique case (dec_kind)
            ACC_CTRL: rd_mux = ctrl_val;
            ACC_GATE: rd_mux = {{(DATA_W-1){1'b0}}, armed[dec_ch]};
            ACC_STAT: rd_mux = {{(DATA_W-1){1'b0}}, drv_irq_i[dec_ch]};
            ACC_ID:   rd_mux = {{(DATA_W-1){1'b0}}, id_strap_i[dec_idx]};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_ok) rdata_q <= rd_mux;
        else            rdata_q <= '0;
    end

    assign bus_rdata_o = rdata_q;
    assign card_irq_o  = |req;

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> (bus_rdata_o == '0));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && dec_kind == ACC_NONE) |=> (bus_rdata_o == '0));

    assert_status_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && dec_kind == ACC_STAT)
            |=> (bus_rdata_o == {{(DATA_W-1){1'b0}}, $past(drv_irq_i[dec_ch])}));

    assert_irq_needs_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        card_irq_o |-> (drv_irq_i != '0));

endmodule

// File: tb/ide_irq_gate_bench.sv
`timescale 1ns/1ps
module ide_irq_gate_bench;

    localparam int ADDR_W = 14;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd = 1'b0, wr = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        line = 2'b00;
    logic [3:0]        strap = 4'b0011;
    logic              card_irq, dma_chan, tf_win, boot_rom;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [DATA_W-1:0] data;
        string             tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;

    always #5 clk = ~clk;

    ide_irq_gate u_ide_irq_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (addr),
        .bus_rd_i    (rd),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .drv_irq_i   (line),
        .id_strap_i  (strap),
        .card_irq_o  (card_irq),
        .dma_chan_o  (dma_chan),
        .tf_window_o (tf_win),
        .boot_rom_o  (boot_rom)
    );

    task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                         input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: one expected item per valid read
    always @(posedge clk) rd_seen <= rd && !wr;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL scoreboard unexpected read actual=%h expected=none", rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rdata, e.data, e.tag);
            end
        end
    end

    task automatic bus_write(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input int a, input logic [DATA_W-1:0] e, input string tag);
        exp_t item;
        @(negedge clk);
        addr = ADDR_W'(a); rd = 1'b1;
        item.data = e; item.tag = tag;
        exp_q.push_back(item);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_drain();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(DATA_W'(card_irq), 8'd0, "R1 card_irq");
        check(DATA_W'(dma_chan), 8'd0, "R1 dma_chan");
        check(DATA_W'(tf_win),   8'd0, "R1 tf_window");
        check(DATA_W'(boot_rom), 8'd1, "R1 boot_rom");
        check(rdata,             8'd0, "R1 rdata");
        bus_read(32'h0000, 8'h00, "R1 ctrl");
        bus_read(32'h2200, 8'h00, "R1 gate0");
        bus_read(32'h3200, 8'h00, "R1 gate1");

        // R5 identity bit order
        bus_read(32'h2280, 8'h01, "R5 id0");
        bus_read(32'h2284, 8'h01, "R5 id1");
        bus_read(32'h2288, 8'h00, "R5 id2");
        bus_read(32'h228C, 8'h00, "R5 id3");
        strap = 4'b1010;
        bus_read(32'h2280, 8'h00, "R5 id0b");
        bus_read(32'h2284, 8'h01, "R5 id1b");
        bus_read(32'h2288, 8'h00, "R5 id2b");
        bus_read(32'h228C, 8'h01, "R5 id3b");

        // R4 status echoes line, masked interrupt stays low (R8)
        line = 2'b01;
        #1 check(DATA_W'(card_irq), 8'd0, "R8 masked");
        bus_read(32'h2290, 8'h01, "R4 stat0");
        bus_read(32'h3290, 8'h00, "R4 stat1");

        // R2 arm channel 0
        bus_write(32'h2200, 8'h5A);
        #1 check(DATA_W'(card_irq), 8'd1, "R2 arm0 irq");
        bus_read(32'h2290, 8'h01, "R4 stat0 no clear");
        #1 check(DATA_W'(card_irq), 8'd1, "R4 no side effect");

        // R3 read clears gate
        bus_read(32'h2200, 8'h01, "R3 gate0 old");
        #1 check(DATA_W'(card_irq), 8'd0, "R3 cleared irq");
        bus_read(32'h2200, 8'h00, "R3 gate0 again");

        // channel 1, isolation of clear
        line = 2'b10;
        bus_write(32'h3200, 8'h00);
        #1 check(DATA_W'(card_irq), 8'd1, "R2 arm1 irq");
        bus_read(32'h2200, 8'h00, "R3 gate0 other");
        #1 check(DATA_W'(card_irq), 8'd1, "R3 isolation");
        bus_read(32'h3200, 8'h01, "R3 gate1 old");
        #1 check(DATA_W'(card_irq), 8'd0, "R3 gate1 cleared");

        // R8 OR over channels
        bus_write(32'h2200, 8'hFF);
        bus_write(32'h3200, 8'h01);
        line = 2'b11;
        #1 check(DATA_W'(card_irq), 8'd1, "R8 both");
        line = 2'b10;
        #1 check(DATA_W'(card_irq), 8'd1, "R8 one");
        line = 2'b00;
        #1 check(DATA_W'(card_irq), 8'd0, "R8 none");

        // R6/R7 control register
        bus_write(32'h0000, 8'h21);
        #1 check({dma_chan, tf_win, boot_rom}, 3'b110, "R6 ctrl 21");
        bus_read(32'h0000, 8'h21, "R6 ctrl rb");
        bus_write(32'h0000, 8'h20);
        #1 check({dma_chan, tf_win, boot_rom}, 3'b010, "R6 ctrl 20");
        bus_write(32'h0000, 8'h00);
        #1 check({dma_chan, tf_win, boot_rom}, 3'b001, "R7 ctrl 00");
        bus_read(32'h0000, 8'h00, "R7 ctrl rb");

        // R9 unmapped access and read-only offsets
        line = 2'b01;
        bus_read(32'h2201, 8'h00, "R9 unmapped 2201");
        bus_read(32'h2204, 8'h00, "R9 unmapped 2204");
        bus_read(32'h1000, 8'h00, "R9 unmapped 1000");
        #1 check(DATA_W'(card_irq), 8'd1, "R9 gate kept");
        bus_write(32'h0001, 8'hFF);
        bus_read(32'h0000, 8'h00, "R9 ctrl untouched");
        bus_read(32'h2200, 8'h01, "R9 clear gate0");
        bus_read(32'h3200, 8'h01, "R9 clear gate1");
        bus_write(32'h2290, 8'hFF);
        bus_write(32'h2284, 8'hFF);
        bus_write(32'h3290, 8'hFF);
        bus_read(32'h2200, 8'h00, "R9 stat wr no arm0");
        bus_read(32'h3200, 8'h00, "R9 stat wr no arm1");

        // R10 collided read and write: write wins, read dropped
        @(negedge clk);
        addr = ADDR_W'(32'h2200); wdata = 8'h00; rd = 1'b1; wr = 1'b1;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        check(rdata, 8'h00, "R10 no data");
        #1 check(DATA_W'(card_irq), 8'd1, "R10 write done");
        bus_read(32'h2200, 8'h01, "R10 gate armed");

        // R11 idle cycle
        @(negedge clk);
        check(rdata, 8'h00, "R11 idle");

        wait_drain();
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule